// File: doc/BRIEF.md
# Burst Address Sequencer with Wrap

This block produces the word address stream for a synchronous burst access to a pseudo-static memory array. A burst opens when the active-low chip-enable is sampled low while the sequencer is idle. The start address is captured on that edge, together with a snapshot of the burst configuration. A programmable number of wait cycles follows. After that the sequencer presents one address per clock and flags each one with a valid strobe.

The configuration register holds three settings: a burst-length code, a wrap-enable bit and an initial latency count. It is written through a one-cycle write strobe. It comes out of reset with defaults, and it may be rewritten at any moment. A running burst always keeps the settings it started with.

A fixed-length burst delivers 4, 8, 16 or 32 words and marks the last one with a done flag. In wrap mode the burst cycles inside the aligned block of its length. Otherwise it counts straight through the address space. A continuous burst runs until chip-enable is released. Releasing chip-enable ends any burst at once.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `word_vld` and `burst_done` are low. The configuration is then continuous, sequential, with latency `LAT_DEF` (default 2), so a burst started without any configuration write behaves that way.
- R2: A burst starts on a clock edge where `ce_n` is low and the block is idle. `start_addr` is captured on that edge, and the first valid word carries exactly that address.
- R3: With latency L, the block counts the start edge as edge 0. `word_vld` stays low after edges 0 to L-1 and first goes high after edge L. L = 0 gives a valid word directly after the start edge.
- R4: Length code `cfg_len_code` 3'b000/001/010/011 selects 4/8/16/32 words. Exactly that many consecutive cycles show `word_vld` high, and `burst_done` is high only together with the last of them. From then on `word_vld` stays low until `ce_n` has been high for a clock edge.
- R5: In a fixed burst with `cfg_wrap`=1 and length N, word i has address (S & ~(N-1)) | ((S+i) & (N-1)), where S is the start address. The bits above log2(N) never change.
- R6: In a fixed burst with `cfg_wrap`=0, word i has address (S+i) mod 2^AW.
- R7: Length codes with bit 2 set (3'b1xx) select a continuous burst. Its addresses follow (S+i) mod 2^AW whatever `cfg_wrap` holds, and `burst_done` never rises.
- R8: `ce_n` sampled high on any edge returns the block to idle. After that edge `word_vld` is low, and a new burst can start on a later edge.
- R9: A configuration write during a burst does not change that burst. This includes a write on the burst's own start edge. The new values apply from the next burst that starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Active-low chip-enable; low opens a burst, high ends it |
| start_addr | input | AW | Word address of the first burst word |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_len_code | input | 3 | Length code: 000=4, 001=8, 010=16, 011=32, 1xx=continuous |
| cfg_wrap | input | 1 | 1 = wrap inside the aligned length block, 0 = sequential |
| cfg_lat | input | LAT_W | Wait cycles between burst start and first word |
| addr_o | output | AW | Current word address |
| word_vld | output | 1 | Address on `addr_o` is a valid burst word |
| burst_done | output | 1 | High with the last word of a fixed-length burst |

## Verification
The hardest case to reach is a configuration write that lands while a burst is in flight. It matters most when the write falls on the very edge where the burst begins, since the snapshot and the register update then meet on that same edge. The bench raises the write strobe in the same cycle that drives `ce_n` low, and writes again in the middle of the data phase. It then checks that the running burst keeps its old length, mode and latency, and that the next burst uses the new ones. Near-exhaustive sweeps over every length code, both modes and start addresses on either side of each alignment boundary cover the wrap arithmetic. A long continuous run crosses the top of the address space.

// File: rtl/burst_seq_pkg.sv
// Package: types and helpers shared by the burst address sequencer.
// Assumes lengths are powers of two from 4 to 32 words.
package burst_seq_pkg;
    localparam int MAX_LEN_LOG2 = 5;
    localparam int IDX_W        = MAX_LEN_LOG2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DATA,
        ST_END
    } seq_state_t;

    typedef struct packed {
        logic [2:0] len_code;
        logic       wrap;
    } burst_mode_t;

    // Length minus one for a fixed-length code (4 << code) - 1.
    function automatic logic [IDX_W-1:0] len_mask(input logic [1:0] code);
        return IDX_W'((4 << code) - 1);
    endfunction
endpackage

// File: rtl/burst_cfg_reg.sv
// Module: burst configuration register.
// Holds length code, wrap bit and latency; loads defaults on reset
// (continuous, sequential, LAT_DEF) and accepts a write on any cycle.
module burst_cfg_reg #(
    parameter int LAT_W   = 4,
    parameter int LAT_DEF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [2:0]       wr_len_code,
    input  logic             wr_wrap,
    input  logic [LAT_W-1:0] wr_lat,
    output logic [2:0]       len_code,
    output logic             wrap,
    output logic [LAT_W-1:0] lat
);
    // Register update: defaults on reset, new value on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_code <= 3'b100;
            wrap     <= 1'b0;
            lat      <= LAT_W'(LAT_DEF);
        end else if (wr) begin
            len_code <= wr_len_code;
            wrap     <= wr_wrap;
            lat      <= wr_lat;
        end
    end
endmodule

// File: rtl/burst_lat_cnt.sv
// Module: initial-latency down-counter.
// Loaded with a nonzero count at burst start; counts down while the
// sequencer waits; flags the final wait cycle.
module burst_lat_cnt #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    input  logic             dec,
    output logic             last_wait
);
    logic [LAT_W-1:0] cnt;

    // Counter: load on start, decrement during the wait phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Final wait cycle once one count remains.
    always_comb last_wait = (cnt <= LAT_W'(1));
endmodule

// File: rtl/burst_addr_step.sv
// Module: burst address register and word index.
// On load takes the start address; on step advances either linearly or
// modulo the burst length inside its aligned block. Assumes AW >= IDX_W.
module burst_addr_step
    import burst_seq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AW-1:0]    load_addr,
    input  logic             step,
    input  logic             wrap_en,
    input  logic [IDX_W-1:0] mask,
    output logic [AW-1:0]    addr,
    output logic [IDX_W-1:0] word_idx
);
    logic [AW-1:0] inc;
    logic [AW-1:0] mask_w;
    logic [AW-1:0] next_addr;

    // Next address: wrap keeps the upper bits, sequential adds one.
    always_comb begin
        inc       = addr + 1'b1;
        mask_w    = AW'(mask);
        next_addr = wrap_en ? ((addr & ~mask_w) | (inc & mask_w)) : inc;
    end

    // Address and index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            word_idx <= '0;
        end else if (load) begin
            addr     <= load_addr;
            word_idx <= '0;
        end else if (step) begin
            addr     <= next_addr;
            word_idx <= word_idx + 1'b1;
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst address sequencer top.
// Opens a burst when ce_n is low in idle, snapshots the configuration,
// waits the latency, then issues one word address per clock until the
// fixed length is reached or ce_n is released.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int AW      = 8,
    parameter int LAT_W   = 4,
    parameter int LAT_DEF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic [AW-1:0]    start_addr,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_len_code,
    input  logic             cfg_wrap,
    input  logic [LAT_W-1:0] cfg_lat,
    output logic [AW-1:0]    addr_o,
    output logic             word_vld,
    output logic             burst_done
);
    seq_state_t       state, state_nx;
    burst_mode_t      snap;
    logic [2:0]       reg_len_code;
    logic             reg_wrap;
    logic [LAT_W-1:0] reg_lat;
    logic             start, last_wait, fixed, last, step;
    logic [IDX_W-1:0] mask, word_idx;

    burst_cfg_reg #(.LAT_W(LAT_W), .LAT_DEF(LAT_DEF)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
        .wr_len_code(cfg_len_code), .wr_wrap(cfg_wrap), .wr_lat(cfg_lat),
        .len_code(reg_len_code), .wrap(reg_wrap), .lat(reg_lat)
    );

    burst_lat_cnt #(.LAT_W(LAT_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .load(start), .load_val(reg_lat),
        .dec(state == ST_WAIT), .last_wait(last_wait)
    );

    burst_addr_step #(.AW(AW)) u_step (
        .clk(clk), .rst_n(rst_n), .load(start), .load_addr(start_addr),
        .step(step), .wrap_en(snap.wrap && fixed), .mask(mask),
        .addr(addr_o), .word_idx(word_idx)
    );

    // Burst decode from the snapshot taken at start.
    always_comb begin
        start = (state == ST_IDLE) && !ce_n;
        fixed = !snap.len_code[2];
        mask  = len_mask(snap.len_code[1:0]);
        last  = fixed && (word_idx == mask);
        step  = (state == ST_DATA) && !ce_n && !last;
    end

    // Output strobes.
    always_comb begin
        word_vld   = (state == ST_DATA);
        burst_done = word_vld && last;
    end

    // Next-state logic; chip-enable release wins over everything.
    always_comb begin
        state_nx = state;
        if (ce_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = (reg_lat == '0) ? ST_DATA : ST_WAIT;
                ST_WAIT: if (last_wait) state_nx = ST_DATA;
                ST_DATA: if (last) state_nx = ST_END;
                ST_END:  state_nx = ST_END;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // State and configuration snapshot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            snap  <= '0;
        end else begin
            state <= state_nx;
            if (start)
                snap <= '{len_code: reg_len_code, wrap: reg_wrap};
        end
    end
endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: protocol checker for the burst address sequencer.
// Watches only the top-level ports; attached by bind below.
module burst_addr_seq_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic [AW-1:0] addr_o,
    input logic          word_vld,
    input logic          burst_done
);
    AST_DONE_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> word_vld); // R4
    AST_DONE_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !word_vld); // R4
    AST_CE_RELEASE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !word_vld); // R8
    AST_FIRST_WORD_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_vld) |-> $past(!ce_n)); // R2
    AST_ADDR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && $past(word_vld)) |-> (addr_o != $past(addr_o))); // R6
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr_o(addr_o),
    .word_vld(word_vld), .burst_done(burst_done)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
// Bench: sweeps length codes, modes, latencies and start addresses;
// expected addresses are computed arithmetically from the requirements.
module burst_addr_seq_bench;
    localparam int AW = 8;
    localparam int LAT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ce_n = 1'b1;
    logic [AW-1:0]    start_addr = '0;
    logic             cfg_wr = 1'b0;
    logic [2:0]       cfg_len_code = '0;
    logic             cfg_wrap = 1'b0;
    logic [LAT_W-1:0] cfg_lat = '0;
    logic [AW-1:0]    addr_o;
    logic             word_vld, burst_done;
    int               n_tests = 0;
    int               n_fail = 0;
    int               cycles = 0;

    burst_addr_seq #(.AW(AW), .LAT_W(LAT_W), .LAT_DEF(2)) u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .start_addr(start_addr),
        .cfg_wr(cfg_wr), .cfg_len_code(cfg_len_code), .cfg_wrap(cfg_wrap),
        .cfg_lat(cfg_lat), .addr_o(addr_o), .word_vld(word_vld),
        .burst_done(burst_done)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input int s, input int i, input int n, input bit wr);
        if (wr) return AW'((s & ~(n - 1)) | ((s + i) & (n - 1)));
        return AW'(s + i);
    endfunction

    task automatic cfg_write(input logic [2:0] code, input bit wr, input int lat);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_len_code = code; cfg_wrap = wr; cfg_lat = LAT_W'(lat);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Open a burst and check a fixed-length run against the given settings.
    task automatic run_fixed(input int s, input int code, input bit wr, input int lat);
        int n;
        n = 4 << code;
        @(negedge clk);
        ce_n = 1'b0; start_addr = AW'(s);
        @(negedge clk);
        for (int k = 0; k < lat; k++) begin
            check(!word_vld, "R3 wait", word_vld, 0);
            @(negedge clk);
        end
        for (int i = 0; i < n; i++) begin
            check(word_vld, "R3/R4 valid", word_vld, 1);
            check(addr_o == exp_addr(s, i, n, wr), wr ? "R5 wrap addr" : "R6 seq addr",
                  addr_o, exp_addr(s, i, n, wr));
            check(burst_done == (i == n - 1), "R4 done", burst_done, (i == n - 1));
            @(negedge clk);
        end
        check(!word_vld && !burst_done, "R4 end quiet", word_vld, 0);
        @(negedge clk);
        check(!word_vld, "R4 end hold", word_vld, 0);
        ce_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!word_vld && !burst_done, "R1 reset outputs", {word_vld, burst_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!word_vld, "R1 idle after reset", word_vld, 0);

        // R1: default config is continuous, sequential, latency 2.
        ce_n = 1'b0; start_addr = 8'h3C;
        @(negedge clk);
        check(!word_vld, "R1 default latency", word_vld, 0);
        @(negedge clk);
        check(!word_vld, "R1 default latency", word_vld, 0);
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            check(word_vld && addr_o == AW'(8'h3C + i), "R1 default seq", addr_o, AW'(8'h3C + i));
            check(!burst_done, "R1 no done", burst_done, 0);
            @(negedge clk);
        end
        ce_n = 1'b1;
        @(negedge clk);
        check(!word_vld, "R8 release", word_vld, 0);

        // R4 R5 R6 R3: sweep lengths, modes, latencies, start addresses.
        for (int code = 0; code < 4; code++)
            for (int wr = 0; wr < 2; wr++)
                for (int s = 0; s < 256; s += 11) begin
                    cfg_write(3'(code), wr[0], s % 4);
                    run_fixed(s, code, wr[0], s % 4);
                end

        // R7: continuous, wrap bit ignored, crosses the top of the space.
        cfg_write(3'b101, 1'b1, 1);
        @(negedge clk);
        ce_n = 1'b0; start_addr = 8'hFA;
        @(negedge clk);
        check(!word_vld, "R3 cont wait", word_vld, 0);
        @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            check(word_vld && addr_o == AW'(8'hFA + i), "R7 cont addr", addr_o, AW'(8'hFA + i));
            check(!burst_done, "R7 no done", burst_done, 0);
            if (i == 299) ce_n = 1'b1;
            @(negedge clk);
        end
        check(!word_vld, "R8 cont release", word_vld, 0);

        // R8: abort a 32-word fixed burst after 3 words, then restart.
        cfg_write(3'b011, 1'b0, 0);
        @(negedge clk);
        ce_n = 1'b0; start_addr = 8'h40;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check(word_vld && addr_o == AW'(8'h40 + i), "R8 pre-abort", addr_o, AW'(8'h40 + i));
            if (i == 2) ce_n = 1'b1;
            @(negedge clk);
        end
        check(!word_vld && !burst_done, "R8 abort", word_vld, 0);
        @(negedge clk);
        check(!word_vld, "R8 idle hold", word_vld, 0);
        run_fixed(8'h44, 3, 1'b0, 0);

        // R9: writes on the start edge and mid-burst do not alter the burst.
        cfg_write(3'b000, 1'b0, 0);
        @(negedge clk);
        ce_n = 1'b0; start_addr = 8'h1E;
        cfg_wr = 1'b1; cfg_len_code = 3'b001; cfg_wrap = 1'b1; cfg_lat = 4'd3;
        @(negedge clk);
        cfg_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(word_vld && addr_o == AW'(8'h1E + i), "R9 old settings addr", addr_o, AW'(8'h1E + i));
            check(burst_done == (i == 3), "R9 old length", burst_done, (i == 3));
            if (i == 1) begin
                cfg_wr = 1'b1; cfg_len_code = 3'b010; cfg_wrap = 1'b1; cfg_lat = 4'd1;
            end else begin
                cfg_wr = 1'b0;
            end
            @(negedge clk);
        end
        check(!word_vld, "R9 old burst ended", word_vld, 0);
        ce_n = 1'b1;
        @(negedge clk);
        run_fixed(8'h1E, 2, 1'b1, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule